// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer with Early Warning

This peripheral is a watchdog that counts down on a slow tick enable, nominally 32768 ticks per second. Software places a 32-bit reload value and a 32-bit warning threshold into the block. Each value is written as two 16-bit halves. A write to the low half of the reload value kicks the watchdog: the counter restarts from the full reload value, and a busy flag stays up for a fixed number of ticks. When the count steps down onto the warning threshold, a sticky warning flag is set. That flag drives a maskable interrupt. When the count runs out, the block can issue a one-cycle reset request and then restarts itself from the reload value.

All configuration registers are shielded by a key register. Only the value 0xE551 written to the key offset opens them, and any other value written there closes them again. While the block is closed, writes to the guarded offsets are dropped. Reads are never blocked. The remaining count can be read as two 16-bit halves.

The bus is a flat, single-cycle register port. A write takes effect at the clock edge where `wrEn` is high. The read data is a combinational function of `addr`.

Top module: `gwdt_top`

## Requirements
- R1: After reset, every offset reads zero, the key offset 0x20 reads 0 (closed), and `irqOut` and `rstReq` are low.
- R2: While closed, writes to offsets 0x00, 0x04, 0x08, 0x0C, 0x14, 0x2C and 0x30 have no effect. Writing 0x0000E551 to 0x20 opens the block, so 0x20 reads 1. Writing any other value to 0x20 closes it again.
- R3: Offsets 0x04/0x00 hold reload bits [31:16]/[15:0], and offsets 0x30/0x2C hold threshold bits [31:16]/[15:0]. Only bits [15:0] of each write are kept, and they read back zero-extended.
- R4: An accepted write to 0x00 reloads the counter with {0x04 contents, new low half}. From the next cycle, 0x1C reads count bits [31:16] and 0x18 reads count bits [15:0].
- R5: Raw status bit 4 (offset 0x10) is set from the cycle after a kick. It clears on the third tick that follows the kick.
- R6: Control bit 1 (offset 0x08) enables counting, and each tick then decrements the count by one, borrowing across the 16-bit halves. With bit 1 clear, the count is frozen.
- R7: When a tick moves the count onto the threshold, raw bit 0 is set and stays set. `irqOut` equals raw bit 0 AND control bit 0 AND NOT bit 0 of the mask register (offset 0x14).
- R8: A tick while the count is zero reloads the count from the reload value. If control bit 3 is set, `rstReq` is high for exactly one cycle and raw bit 3 is set. If bit 3 is clear, neither happens.
- R9: Writing 1 to bit 0 or bit 3 of offset 0x0C, while open, clears raw bit 0 or raw bit 3 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | One-cycle count tick (about 32768 per second) |
| wrEn | input | 1 | Register write strobe |
| addr | input | 6 | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` (combinational) |
| irqOut | output | 1 | Early-warning interrupt |
| rstReq | output | 1 | One-cycle reset request on expiry |

## Verification
A wrong count shows at offsets 0x18/0x1C at the sample point after the very next tick. It also shifts when raw bit 0 and `rstReq` appear, because both are tied to exact count values. A stuck or miscounted busy counter is visible on raw bit 4 after the first, second or third tick that follows a kick. A wrong key state shows immediately: a guarded register that should hold its old value reads back the new data, or the reverse. The bench sweeps small reload values against every threshold position below them. This exposes any error in the threshold comparison, or any off-by-one at expiry, within a few ticks.

// File: rtl/gwdt_pkg.sv
package gwdt_pkg;
  localparam int HALF_W = 16;
  localparam int CNT_W  = 2 * HALF_W;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFF_LDLO  = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_LDHI  = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_RAW   = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_CNTLO = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_CNTHI = 6'h1C;
  localparam logic [ADDR_W-1:0] OFF_KEY   = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_PRLO  = 6'h2C;
  localparam logic [ADDR_W-1:0] OFF_PRHI  = 6'h30;

  localparam logic [CNT_W-1:0] OPEN_KEY = 32'h0000_E551;

  // control-to-datapath strobes and live configuration
  typedef struct packed {
    logic             kick;
    logic             clrInt;
    logic             clrRst;
    logic             cntEn;
    logic             rstEn;
    logic [CNT_W-1:0] loadVal;
    logic [CNT_W-1:0] preVal;
  } ctlStrobe_t;
endpackage

// File: rtl/gwdt_ctrl.sv
module gwdt_ctrl
  import gwdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              rawInt,
  input  logic              rawRst,
  input  logic              busy,
  output ctlStrobe_t        strobe,
  output logic              unlocked,
  output logic              irqOut,
  output logic [CNT_W-1:0]  rdData
);
  logic [HALF_W-1:0] loadLo, loadHi, preLo, preHi;
  logic [3:0]        ctrlReg;
  logic              maskReg;
  logic              guardedWr;

  assign guardedWr = wrEn && unlocked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlocked <= 1'b0;
      loadLo   <= '0;
      loadHi   <= '0;
      preLo    <= '0;
      preHi    <= '0;
      ctrlReg  <= '0;
      maskReg  <= 1'b0;
    end else begin
      if (wrEn && addr == OFF_KEY) begin
        unlocked <= (wrData == OPEN_KEY);
      end
      if (guardedWr) begin
        case (addr)
          OFF_LDLO: loadLo  <= wrData[HALF_W-1:0];
          OFF_LDHI: loadHi  <= wrData[HALF_W-1:0];
          OFF_PRLO: preLo   <= wrData[HALF_W-1:0];
          OFF_PRHI: preHi   <= wrData[HALF_W-1:0];
          OFF_CTRL: ctrlReg <= wrData[3:0];
          OFF_MASK: maskReg <= wrData[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strobe.kick    = guardedWr && addr == OFF_LDLO;
    strobe.clrInt  = guardedWr && addr == OFF_CLR && wrData[0];
    strobe.clrRst  = guardedWr && addr == OFF_CLR && wrData[3];
    strobe.cntEn   = ctrlReg[1];
    strobe.rstEn   = ctrlReg[3];
    strobe.loadVal = {loadHi, strobe.kick ? wrData[HALF_W-1:0] : loadLo};
    strobe.preVal  = {preHi, preLo};
  end

  assign irqOut = rawInt && ctrlReg[0] && !maskReg;

  always_comb begin
    rdData = '0;
    case (addr)
      OFF_LDLO:  rdData[HALF_W-1:0] = loadLo;
      OFF_LDHI:  rdData[HALF_W-1:0] = loadHi;
      OFF_CTRL:  rdData[3:0]        = ctrlReg;
      OFF_RAW:   rdData[4:0]        = {busy, rawRst, 2'b00, rawInt};
      OFF_MASK:  rdData[0]          = maskReg;
      OFF_CNTLO: rdData[HALF_W-1:0] = cntVal[HALF_W-1:0];
      OFF_CNTHI: rdData[HALF_W-1:0] = cntVal[CNT_W-1:HALF_W];
      OFF_KEY:   rdData[0]          = unlocked;
      OFF_PRLO:  rdData[HALF_W-1:0] = preLo;
      OFF_PRHI:  rdData[HALF_W-1:0] = preHi;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/gwdt_datapath.sv
module gwdt_datapath
  import gwdt_pkg::*;
#(
  parameter int BUSY_TICKS = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  ctlStrobe_t       strobe,
  output logic [CNT_W-1:0] cntVal,
  output logic             rawInt,
  output logic             rawRst,
  output logic             busy,
  output logic             rstReq
);
  localparam int BUSY_W = $clog2(BUSY_TICKS + 1);
  localparam logic [BUSY_W-1:0] BUSY_INIT = BUSY_W'(BUSY_TICKS);

  logic [BUSY_W-1:0] busyCnt;
  logic              step, expire, hitPre;
  logic [CNT_W-1:0]  cntDec;

  assign step   = !strobe.kick && strobe.cntEn && tickEn;
  assign cntDec = cntVal - 1'b1;
  assign expire = step && cntVal == '0;
  assign hitPre = step && cntVal != '0 && cntDec == strobe.preVal;
  assign busy   = busyCnt != '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal  <= '0;
      busyCnt <= '0;
      rawInt  <= 1'b0;
      rawRst  <= 1'b0;
      rstReq  <= 1'b0;
    end else begin
      rstReq <= expire && strobe.rstEn;
      if (strobe.kick) begin
        cntVal <= strobe.loadVal;
      end else if (expire) begin
        cntVal <= strobe.loadVal;
      end else if (step) begin
        cntVal <= cntDec;
      end

      if (strobe.kick) begin
        busyCnt <= BUSY_INIT;
      end else if (tickEn && busy) begin
        busyCnt <= busyCnt - 1'b1;
      end

      if (hitPre) begin
        rawInt <= 1'b1;
      end else if (strobe.clrInt) begin
        rawInt <= 1'b0;
      end

      if (expire && strobe.rstEn) begin
        rawRst <= 1'b1;
      end else if (strobe.clrRst) begin
        rawRst <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gwdt_top.sv
module gwdt_top
  import gwdt_pkg::*;
#(
  parameter int BUSY_TICKS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic              irqOut,
  output logic              rstReq
);
  ctlStrobe_t       strobe;
  logic [CNT_W-1:0] cntVal;
  logic             rawInt, rawRst, busy, unlocked;

  gwdt_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .cntVal(cntVal), .rawInt(rawInt), .rawRst(rawRst), .busy(busy),
    .strobe(strobe), .unlocked(unlocked), .irqOut(irqOut), .rdData(rdData)
  );

  gwdt_datapath #(.BUSY_TICKS(BUSY_TICKS)) dp_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strobe(strobe),
    .cntVal(cntVal), .rawInt(rawInt), .rawRst(rawRst), .busy(busy),
    .rstReq(rstReq)
  );
endmodule

// File: rtl/gwdt_checker.sv
module gwdt_checker
  import gwdt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic              irqOut,
  input logic              rstReq,
  input ctlStrobe_t        strobe,
  input logic [CNT_W-1:0]  cntVal,
  input logic              rawInt,
  input logic              rawRst,
  input logic              busy,
  input logic              unlocked
);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);

  a_r8_pulse_sets_raw: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> rawRst);

  a_r5_busy_after_kick: assert property (@(posedge clk) disable iff (!rstN)
    strobe.kick |=> busy);

  a_r6_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.cntEn && !strobe.kick) |=> $stable(cntVal));

  a_r6_decrement: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cntEn && tickEn && !strobe.kick && cntVal != '0)
      |=> cntVal == $past(cntVal) - 1'b1);

  a_r2_closed_keeps_reload: assert property (@(posedge clk) disable iff (!rstN)
    (!unlocked && wrEn && addr == OFF_LDHI) |=> $stable(strobe.loadVal[CNT_W-1:HALF_W]));

  a_r7_irq_needs_raw: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> rawInt);
endmodule

bind gwdt_top gwdt_checker chk_i (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
  .irqOut(irqOut), .rstReq(rstReq), .strobe(strobe), .cntVal(cntVal),
  .rawInt(rawInt), .rawRst(rawRst), .busy(busy), .unlocked(unlocked)
);

// File: tb/gwdt_top_tb.sv
module gwdt_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut, rstReq;
  int          compared = 0;
  int          mismatched = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  gwdt_top dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut), .rstReq(rstReq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic tick();
    @(negedge clk);
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic readCount(output logic [31:0] c);
    logic [31:0] hi, lo;
    rd(6'h1C, hi);
    rd(6'h18, lo);
    c = {hi[15:0], lo[15:0]};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a <= 6'h30; a += 4) begin
      rd(6'(a), v);
      check($sformatf("R1 offset %0h", a), v, 32'h0);
    end
    check("R1 irqOut", {31'b0, irqOut}, 32'h0);
    check("R1 rstReq", {31'b0, rstReq}, 32'h0);

    // R2 closed writes ignored
    wr(6'h04, 32'h1234);
    rd(6'h04, v); check("R2 closed write dropped", v, 32'h0);
    wr(6'h08, 32'hF);
    rd(6'h08, v); check("R2 closed ctrl dropped", v, 32'h0);
    wr(6'h20, 32'h0000E551);
    rd(6'h20, v); check("R2 key opens", v, 32'h1);
    // R3 halves keep 16 bits
    wr(6'h04, 32'hABCD1234);
    rd(6'h04, v); check("R3 reload high", v, 32'h1234);
    wr(6'h30, 32'hFFFF0007);
    rd(6'h30, v); check("R3 threshold high", v, 32'h7);
    wr(6'h2C, 32'h00018888);
    rd(6'h2C, v); check("R3 threshold low", v, 32'h8888);
    wr(6'h20, 32'h0);
    rd(6'h20, v); check("R2 relock", v, 32'h0);
    wr(6'h04, 32'h5);
    rd(6'h04, v); check("R2 relocked write dropped", v, 32'h1234);
    wr(6'h20, 32'h0001E551);
    rd(6'h20, v); check("R2 wrong key keeps closed", v, 32'h0);
    wr(6'h20, 32'h0000E551);

    // R4 kick and R5 busy
    wr(6'h04, 32'h0);
    wr(6'h30, 32'h0);
    wr(6'h2C, 32'h0);
    wr(6'h00, 32'd20);
    readCount(c); check("R4 kick loads count", c, 32'd20);
    rd(6'h10, v); check("R5 busy after kick", v & 32'h10, 32'h10);
    tick(); rd(6'h10, v); check("R5 busy after tick1", v & 32'h10, 32'h10);
    tick(); rd(6'h10, v); check("R5 busy after tick2", v & 32'h10, 32'h10);
    tick(); rd(6'h10, v); check("R5 busy clear after tick3", v & 32'h10, 32'h0);
    readCount(c); check("R6 frozen while disabled", c, 32'd20);

    // R6/R7/R8 sweep: ctrl = irqEn|cntEn|rstEn
    wr(6'h08, 32'hB);
    for (int L = 2; L <= 9; L++) begin
      for (int p = 0; p < L; p++) begin
        wr(6'h2C, 32'(p));
        wr(6'h0C, 32'h9);
        wr(6'h00, 32'(L));
        for (int k = 1; k <= L; k++) begin
          tick();
          readCount(c);
          check($sformatf("R6 L=%0d p=%0d k=%0d count", L, p, k), c, 32'(L - k));
          rd(6'h10, v);
          check($sformatf("R7 L=%0d p=%0d k=%0d raw0", L, p, k), v & 1, ((L - k) <= p) ? 1 : 0);
          check($sformatf("R7 L=%0d p=%0d k=%0d irq", L, p, k), {31'b0, irqOut}, ((L - k) <= p) ? 1 : 0);
          check($sformatf("R8 no early pulse L=%0d k=%0d", L, k), {31'b0, rstReq}, 32'h0);
        end
        tick();
        check($sformatf("R8 pulse L=%0d p=%0d", L, p), {31'b0, rstReq}, 32'h1);
        readCount(c); check($sformatf("R8 reload L=%0d", L), c, 32'(L));
        rd(6'h10, v); check("R8 raw3 set", v & 32'h8, 32'h8);
        @(negedge clk);
        check("R8 pulse one cycle", {31'b0, rstReq}, 32'h0);
      end
    end

    // R7 mask, R9 clear, R2 closed clear
    wr(6'h14, 32'h1);
    rd(6'h10, v); check("R7 raw0 pending", v & 1, 32'h1);
    check("R7 masked irq", {31'b0, irqOut}, 32'h0);
    wr(6'h14, 32'h0);
    check("R7 unmasked irq", {31'b0, irqOut}, 32'h1);
    wr(6'h08, 32'hA);
    check("R7 irq disabled", {31'b0, irqOut}, 32'h0);
    wr(6'h20, 32'h0);
    wr(6'h0C, 32'h9);
    rd(6'h10, v); check("R9 closed clear ignored", v & 32'h9, 32'h9);
    wr(6'h20, 32'h0000E551);
    wr(6'h0C, 32'h1);
    rd(6'h10, v); check("R9 clear bit0 only", v & 32'h9, 32'h8);
    wr(6'h0C, 32'h8);
    rd(6'h10, v); check("R9 clear bit3", v & 32'h9, 32'h0);

    // R8 expiry without reset enable (ctrl = cntEn only)
    wr(6'h08, 32'h2);
    wr(6'h2C, 32'h100);
    wr(6'h00, 32'h1);
    tick();
    readCount(c); check("R8 count at zero", c, 32'h0);
    tick();
    check("R8 no pulse when disabled", {31'b0, rstReq}, 32'h0);
    readCount(c); check("R8 reload without reset", c, 32'h1);
    rd(6'h10, v); check("R8 raw3 stays clear", v & 32'h8, 32'h0);

    // R6 borrow across halves
    wr(6'h04, 32'h1);
    wr(6'h00, 32'h2);
    readCount(c); check("R4 two-half kick", c, 32'h10002);
    tick(); tick(); tick();
    rd(6'h1C, v); check("R6 borrow high half", v, 32'h0);
    rd(6'h18, v); check("R6 borrow low half", v, 32'hFFFF);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule